// File: doc/BRIEF.md
# Two-Level Microprogram Sequencer with Shared Control-Pattern Store

This block sequences control for a microcoded datapath using two tiers of writable storage. A micro-address register selects a narrow 17-bit microword from the sequence store. Each microword does one of two things. It can redirect the micro-address to a new location. It can instead name an entry in a much wider 68-bit pattern store, and that entry is presented to the datapath as the control word for the cycle.

Many microwords that need the same control pattern can name one shared pattern entry, so the wide store stays small. Both stores are RAMs with their own write ports. They are normally filled while reset is held and can be patched at any time afterwards. An external dispatch pulse loads a start address, which is how an instruction decoder enters a routine.

Decoding the 68-bit control word into individual datapath signals happens outside this block.

Top module: `nseq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0, `ctl_valid` is 0 and `ctl_word` is all zero. After reset is released, sequencing starts at micro-address 0.
- R2: A microword with bit 16 = 0 is a pointer word. The bench drives its bits [8:0] as an index into the pattern store. `ctl_word` equals that pattern entry and `ctl_valid` is 1 in the same cycle. On the next clock `upc` becomes `upc + 1`.
- R3: A microword with bit 16 = 1 is a jump word. `ctl_valid` is 0, and on the next clock `upc` becomes the word's bits [9:0].
- R4: When `dsp_go` is high at a clock edge, `upc` loads `dsp_addr` on that edge. This holds whichever form the current microword has.
- R5: When a pointer word sits at address 1023, `upc` wraps to 0 on the next clock.
- R6: A write to the sequence store takes effect at the rising edge. A write to the address that `upc` moves to is seen in the very next cycle. A write to the current address does not change the current cycle's outputs.
- R7: A write to the pattern store takes effect at the rising edge. Two pointer words that name the same pattern entry produce identical `ctl_word` values.
- R8: Bits [15:10] of a jump word and bits [15:9] of a pointer word have no effect on `upc`, `ctl_valid` or `ctl_word`.
- R9: `ctl_word` is all zero whenever `ctl_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_go | input | 1 | Dispatch strobe, loads `dsp_addr` into `upc` |
| dsp_addr | input | 10 | Dispatch start address |
| sq_we | input | 1 | Sequence-store write enable |
| sq_waddr | input | 10 | Sequence-store write address |
| sq_wdata | input | 17 | Sequence-store write data |
| pt_we | input | 1 | Pattern-store write enable |
| pt_waddr | input | 9 | Pattern-store write address |
| pt_wdata | input | 68 | Pattern-store write data |
| upc | output | 10 | Current micro-address |
| ctl_word | output | 68 | Control word issued this cycle |
| ctl_valid | output | 1 | High when `ctl_word` carries a pattern entry |

## Verification
The bench goes after these corner cases:

- **Micro-address wrap at 1023.** A design with a wrong-width increment would leave the range or stick at the top.
- **Dispatch arriving on a jump word.** A design that lets the jump win would ignore the decoder.
- **Jump words that target themselves.** These check that `ctl_valid` stays low across a loop.
- **Reserved bits set in both microword forms.** A design that decodes too many bits would fetch a wrong pattern or jump to a wrong target.
- **Writes into the store at the current or next micro-address, and into the pattern entry being read.** These separate write-before-read from read-before-write behaviour.
- **Reset asserted in the middle of a run.** This must clear `upc` at once, without waiting for a clock.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int unsigned SQ_WORD_W  = 17;
  localparam int unsigned SQ_DEPTH   = 1024;
  localparam int unsigned PT_WORD_W  = 68;
  localparam int unsigned PT_DEPTH   = 512;
  localparam int unsigned FORM_BIT   = 16;
  localparam int unsigned SQ_ADDR_W  = $clog2(SQ_DEPTH);
  localparam int unsigned PT_ADDR_W  = $clog2(PT_DEPTH);

  typedef enum logic {
    FORM_POINTER = 1'b0,
    FORM_JUMP    = 1'b1
  } uform_e;
endpackage

// File: rtl/nseq_ram.sv
module nseq_ram #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // write takes effect at the rising edge
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // combinational read of the addressed entry
  assign rdata = mem[raddr];
endmodule

// File: rtl/nseq_next.sv
module nseq_next
  import nseq_pkg::*;
#(
  parameter int unsigned UAW = SQ_ADDR_W,
  parameter int unsigned PAW = PT_ADDR_W,
  parameter int unsigned FB  = FORM_BIT
) (
  input  logic [UAW-1:0] upc_q,
  input  logic           form,
  input  logic [UAW-1:0] jmp_tgt,
  input  logic           dsp_go,
  input  logic [UAW-1:0] dsp_addr,
  output logic [UAW-1:0] upc_d,
  output logic           issue
);
  uform_e kind;

  always_comb begin
    kind  = uform_e'(form);
    issue = (kind == FORM_POINTER);
    if (dsp_go) begin
      upc_d = dsp_addr;
    end else if (kind == FORM_JUMP) begin
      upc_d = jmp_tgt;
    end else begin
      upc_d = upc_q + UAW'(1);
    end
  end
endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int unsigned SW = SQ_WORD_W,
  parameter int unsigned SD = SQ_DEPTH,
  parameter int unsigned PW = PT_WORD_W,
  parameter int unsigned PD = PT_DEPTH,
  parameter int unsigned FB = FORM_BIT,
  localparam int unsigned UAW = $clog2(SD),
  localparam int unsigned PAW = $clog2(PD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dsp_go,
  input  logic [UAW-1:0] dsp_addr,
  input  logic           sq_we,
  input  logic [UAW-1:0] sq_waddr,
  input  logic [SW-1:0]  sq_wdata,
  input  logic           pt_we,
  input  logic [PAW-1:0] pt_waddr,
  input  logic [PW-1:0]  pt_wdata,
  output logic [UAW-1:0] upc,
  output logic [PW-1:0]  ctl_word,
  output logic           ctl_valid
);
  logic [UAW-1:0] upc_q;
  logic [UAW-1:0] upc_d;
  logic           upc_en;
  logic [SW-1:0]  uword;
  logic [PW-1:0]  pt_rd;
  logic           issue;

  nseq_ram #(.WIDTH(SW), .DEPTH(SD)) u_seq_store (
    .clk   (clk),
    .we    (sq_we),
    .waddr (sq_waddr),
    .wdata (sq_wdata),
    .raddr (upc_q),
    .rdata (uword)
  );

  nseq_ram #(.WIDTH(PW), .DEPTH(PD)) u_pat_store (
    .clk   (clk),
    .we    (pt_we),
    .waddr (pt_waddr),
    .wdata (pt_wdata),
    .raddr (uword[PAW-1:0]),
    .rdata (pt_rd)
  );

  nseq_next #(.UAW(UAW), .PAW(PAW), .FB(FB)) u_next (
    .upc_q    (upc_q),
    .form     (uword[FB]),
    .jmp_tgt  (uword[UAW-1:0]),
    .dsp_go   (dsp_go),
    .dsp_addr (dsp_addr),
    .upc_d    (upc_d),
    .issue    (issue)
  );

  // the sequencer advances every cycle out of reset
  assign upc_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q <= '0;
    end else if (upc_en) begin
      upc_q <= upc_d;
    end
  end

  always_comb begin
    ctl_valid = rst_n & issue;
    ctl_word  = ctl_valid ? pt_rd : '0;
  end

  assign upc = upc_q;
endmodule

// File: rtl/nseq_ctrl_chk.sv
module nseq_ctrl_chk #(
  parameter int unsigned UAW = 10,
  parameter int unsigned PW  = 68,
  parameter int unsigned SW  = 17
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dsp_go,
  input logic [UAW-1:0] dsp_addr,
  input logic [UAW-1:0] upc,
  input logic [PW-1:0]  ctl_word,
  input logic           ctl_valid,
  input logic [SW-1:0]  uword
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> upc == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !dsp_go) |=> upc == UAW'($past(upc) + 1'b1));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_valid && !dsp_go) |=> upc == $past(uword[UAW-1:0]));

  assert_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_go |=> upc == $past(dsp_addr));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid |-> ctl_word == '0);
endmodule

bind nseq_ctrl nseq_ctrl_chk #(.UAW(UAW), .PW(PW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dsp_go    (dsp_go),
  .dsp_addr  (dsp_addr),
  .upc       (upc),
  .ctl_word  (ctl_word),
  .ctl_valid (ctl_valid),
  .uword     (uword)
);

// File: tb/nseq_ctrl_tb.sv
`timescale 1ns/1ps
module nseq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dsp_go;
  logic [9:0]  dsp_addr;
  logic        sq_we;
  logic [9:0]  sq_waddr;
  logic [16:0] sq_wdata;
  logic        pt_we;
  logic [8:0]  pt_waddr;
  logic [67:0] pt_wdata;
  logic [9:0]  upc;
  logic [67:0] ctl_word;
  logic        ctl_valid;

  always #4 clk = ~clk;

  nseq_ctrl u_dut (.*);

  // reference model state
  logic [16:0] m_sq [1024];
  logic [67:0] m_pt [512];
  int unsigned m_upc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [67:0] pat(input int i);
    return {4'hC, 32'(i * 32'h9E3779B1), 23'(i * 5 + 1), 9'(i)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [9:0]  e_upc;
    logic        e_v;
    logic [67:0] e_w;
    logic [16:0] w;
    #1;
    e_upc = rst_n ? 10'(m_upc) : 10'd0;
    w     = m_sq[e_upc];
    e_v   = rst_n && (w[16] == 1'b0);
    e_w   = e_v ? m_pt[w[8:0]] : 68'd0;
    chk(tag, "upc", 68'(upc), 68'(e_upc));
    chk(tag, "valid", 68'(ctl_valid), 68'(e_v));
    chk(tag, "word", ctl_word, e_w);
    @(posedge clk);
    if (!rst_n)          m_upc = 0;
    else if (dsp_go)     m_upc = dsp_addr;
    else if (w[16])      m_upc = w[9:0];
    else                 m_upc = (m_upc + 1) % 1024;
    if (sq_we) m_sq[sq_waddr] = sq_wdata;
    if (pt_we) m_pt[pt_waddr] = pt_wdata;
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic disp(input int a, input string tag);
    dsp_go = 1; dsp_addr = 10'(a); cyc(tag); dsp_go = 0;
  endtask

  task automatic sqw(input int a, input logic [16:0] d, input string tag);
    sq_we = 1; sq_waddr = 10'(a); sq_wdata = d; cyc(tag); sq_we = 0;
  endtask

  task automatic ptw(input int a, input logic [67:0] d, input string tag);
    pt_we = 1; pt_waddr = 9'(a); pt_wdata = d; cyc(tag); pt_we = 0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dsp_go = 0; dsp_addr = '0;
    sq_we = 0; sq_waddr = '0; sq_wdata = '0;
    pt_we = 0; pt_waddr = '0; pt_wdata = '0;
    m_upc = 0;
    for (int i = 0; i < 1024; i++) m_sq[i] = '0;
    for (int i = 0; i < 512; i++)  m_pt[i] = '0;
    @(negedge clk);
    // R1: fill both stores while reset holds the sequencer at 0
    for (int i = 0; i < 512; i++) ptw(i, pat(i), "R1");
    for (int i = 0; i < 1024; i++) sqw(i, {1'b0, 7'd0, 9'(i) ^ 9'h55}, "R1");
    rst_n = 1;
    // R2: straight-line pointer words
    run(20, "R2");
    // R5: wrap past the top of the sequence store
    disp(1020, "R4");
    run(6, "R5");
    // R3 / R8: jump with reserved bits set, pointer with reserved bits set
    sqw(100, {1'b1, 6'h3F, 10'd300}, "R8");
    sqw(300, {1'b0, 7'h7F, 9'd17}, "R8");
    disp(98, "R4");
    run(6, "R3");
    // R3 / R9: self loop keeps valid low and word zero
    sqw(400, {1'b1, 6'd0, 10'd400}, "R3");
    disp(400, "R4");
    run(4, "R9");
    // R4: dispatch wins over a jump word, then over a pointer word
    disp(50, "R4");
    cyc("R4");
    disp(700, "R4");
    run(2, "R4");
    // R6: patch the next address and the current address while running
    disp(200, "R6");
    sqw(201, {1'b1, 6'd0, 10'd640}, "R6");
    run(3, "R6");
    sqw(642, {1'b1, 6'd0, 10'd10}, "R6");
    run(3, "R6");
    // R7: overwrite the pattern entry being read; shared entries
    disp(600, "R7");
    sqw(600, {1'b0, 7'd0, 9'd7}, "R7");
    sqw(601, {1'b0, 7'd0, 9'd7}, "R7");
    disp(600, "R7");
    ptw(7, 68'h0_1234_5678_9ABC_DEF0, "R7");
    run(3, "R7");
    disp(600, "R7");
    run(2, "R7");
    // R1: reset in mid-run clears upc at once
    disp(333, "R4");
    run(2, "R2");
    rst_n = 0;
    run(2, "R1");
    rst_n = 1;
    run(4, "R1");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule